// File: doc/BRIEF.md
# Battery Charge Stage Sequencer

This block is the control state machine of a nickel-chemistry battery charger. It decides which charging stage the charger is in and tells the pulse generator what kind of current pattern to apply. After reset it polls the battery input for a fixed window without charging. When a battery is found it goes to a cold-battery low-rate charge or to a soft-start ramp. From soft-start it moves to full-rate fast charge, then a timed topping charge, then a maintenance charge that lasts as long as the battery stays connected. Overvoltage, undervoltage or overtemperature puts it into a shutdown state. That state is held until the battery is removed.

All measurements arrive as single-bit flags. These are battery present, overvoltage, undervoltage, hot, cold, slope termination and fast-charge timeout. Every duration is counted in one-millisecond ticks by a stage timer that clears each time the stage changes. A two-bit rate select picks the charge rate. Its low bit chooses short or long soft-start, topping and indicator blink timing, and the rate is latched when the machine leaves polling. The indicator output sinks current steadily during soft-start and fast charge, blinks during the low-rate stages, and stays open when idle or shut down.

Top module: `chg_seq`

## Requirements
- R1: While reset is high and in the first cycle after it is released, the stage is polling (code 0), the mode is off (code 0) and the indicator is open (`ind_sink_o` = 0).
- R2: In polling, the mode stays off. The polling window ends once POLL_MS ticks have counted since entering the stage. In the cycle after that, a present battery with no overvoltage or hot flag moves the stage to soft-start (code 1), or to cold charge (code 5) if the cold flag is high.
- R3: In polling, an overvoltage flag after the window ends moves the stage to fault (code 6), even when no battery is present.
- R4: Soft-start moves to fast charge (code 2) on the tick that completes SS_SHORT_MS ticks when the latched rate bit 0 is 0 (rates 00 = 4C, 10 = 1C), or SS_LONG_MS ticks when it is 1 (01 = 2C, 11 = C/2). The stage change happens at the clock edge that samples the tick.
- R5: Fast charge continues until the slope-termination flag or the fast-timeout flag is seen. Either flag moves it to topping (code 3) at the next edge.
- R6: Topping moves to maintenance (code 4) on the tick that completes TOP_SHORT_MS ticks (rate bit 0 = 0) or TOP_LONG_MS ticks (rate bit 0 = 1).
- R7: Maintenance holds for as long as the battery is present and no fault flag is high. When the battery is removed, the stage returns to polling at the next edge.
- R8: The cold flag is sampled only when polling ends. Cold charge uses the topping mode code. When the cold flag drops, the stage moves to soft-start at the next edge. The cold flag has no effect in soft-start, fast charge, topping or maintenance.
- R9: In any charging stage (codes 1 to 5), overvoltage, undervoltage or hot moves the stage to fault at the next edge. This takes priority over every other transition.
- R10: Fault holds while the battery-present flag is high and returns to polling at the edge after the flag drops. The mode is off in fault.
- R11: Mode codes follow the stage: off in polling and fault, ramp (1) in soft-start, full (2) in fast, topping (3) in topping and cold charge, maintenance (4) in maintenance. The mode changes at the same edge as the stage.
- R12: `ind_sink_o` is 1 in soft-start and fast charge and 0 in polling and fault. In topping, maintenance and cold charge it starts at 1 on stage entry and inverts every BLINK_SHORT_MS ticks (rate bit 0 = 0) or BLINK_LONG_MS ticks (rate bit 0 = 1).
- R13: The rate select is latched when polling ends. Later changes to it do not alter soft-start, topping or blink timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| rate_sel_i | input | 2 | Charge rate: 00 4C, 01 2C, 10 1C, 11 C/2 |
| bat_present_i | input | 1 | Battery detected at the sense input |
| ov_i | input | 1 | Overvoltage flag |
| uv_i | input | 1 | Undervoltage flag |
| hot_i | input | 1 | Overtemperature flag |
| cold_i | input | 1 | Battery-too-cold flag |
| slope_end_i | input | 1 | Voltage-slope or peak termination seen |
| fast_tmo_i | input | 1 | Fast-charge timeout expired |
| stage_o | output | 3 | Current stage code |
| mode_o | output | 3 | Current pattern code for the pulse generator |
| ind_sink_o | output | 1 | 1 = indicator pin pulled low (lamp on), 0 = open |

## Verification
Flag-driven transitions (termination, fault, removal, cold release, end of polling) appear on the stage, mode and indicator outputs one clock edge after the flag is driven, so the bench drives flags on a falling edge and checks on the next falling edge. A timed transition happens at the edge that samples the completing tick. The bench therefore drives each tick as a single-cycle pulse starting on a falling edge and checks on the following falling edge, after counting exactly how many ticks have been applied since the stage was entered. The end of the polling window is different. The final tick only fills the counter, and the transition follows one cycle later, which the bench waits for before checking. All four rates are swept. For each one, the expected durations are computed from its low bit while the rate select is deliberately flipped after latching.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [2:0] {
    ST_POLL  = 3'd0,
    ST_SOFT  = 3'd1,
    ST_FAST  = 3'd2,
    ST_TOP   = 3'd3,
    ST_MAINT = 3'd4,
    ST_COLD  = 3'd5,
    ST_FAULT = 3'd6
  } stage_e;

  typedef enum logic [2:0] {
    MD_OFF   = 3'd0,
    MD_RAMP  = 3'd1,
    MD_FULL  = 3'd2,
    MD_TOPUP = 3'd3,
    MD_KEEP  = 3'd4
  } mode_e;

  function automatic mode_e mode_of(stage_e s);
    case (s)
      ST_SOFT:          return MD_RAMP;
      ST_FAST:          return MD_FULL;
      ST_TOP, ST_COLD:  return MD_TOPUP;
      ST_MAINT:         return MD_KEEP;
      default:          return MD_OFF;
    endcase
  endfunction

  function automatic logic is_charging(stage_e s);
    return (s == ST_SOFT) || (s == ST_FAST) || (s == ST_TOP) ||
           (s == ST_MAINT) || (s == ST_COLD);
  endfunction

  function automatic logic is_blinking(stage_e s);
    return (s == ST_TOP) || (s == ST_MAINT) || (s == ST_COLD);
  endfunction

endpackage

// File: rtl/chg_timer.sv
module chg_timer #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick && (cnt != CMAX)) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/chg_blink.sv
module chg_blink #(
  parameter int BLINK_SHORT_MS = 1000,
  parameter int BLINK_LONG_MS  = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic tick,
  input  logic long_sel,
  output logic phase
);
  localparam int BW = $clog2(BLINK_LONG_MS + 1);
  localparam logic [BW-1:0] HS_LAST = BW'(BLINK_SHORT_MS - 1);
  localparam logic [BW-1:0] HL_LAST = BW'(BLINK_LONG_MS - 1);

  logic [BW-1:0] bcnt;
  logic [BW-1:0] last;

  assign last = long_sel ? HL_LAST : HS_LAST;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bcnt  <= '0;
      phase <= 1'b1;
    end else if (en && tick) begin
      if (bcnt == last) begin
        bcnt  <= '0;
        phase <= ~phase;
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/chg_next.sv
module chg_next
  import chg_pkg::*;
(
  input  stage_e stage_q,
  input  logic   poll_done,
  input  logic   ss_done,
  input  logic   top_done,
  input  logic   present,
  input  logic   ov,
  input  logic   uv,
  input  logic   hot,
  input  logic   cold,
  input  logic   slope_end,
  input  logic   fast_tmo,
  output stage_e stage_d
);
  logic chg_fault;
  assign chg_fault = ov || uv || hot;

  always_comb begin
    stage_d = stage_q;
    if (is_charging(stage_q) && chg_fault) begin
      stage_d = ST_FAULT;
    end else if (is_charging(stage_q) && !present) begin
      stage_d = ST_POLL;
    end else begin
      case (stage_q)
        ST_POLL: begin
          if (poll_done) begin
            if (ov || hot)    stage_d = ST_FAULT;
            else if (present) stage_d = cold ? ST_COLD : ST_SOFT;
          end
        end
        ST_SOFT:  if (ss_done) stage_d = ST_FAST;
        ST_FAST:  if (slope_end || fast_tmo) stage_d = ST_TOP;
        ST_TOP:   if (top_done) stage_d = ST_MAINT;
        ST_MAINT: stage_d = ST_MAINT;
        ST_COLD:  if (!cold) stage_d = ST_SOFT;
        ST_FAULT: if (!present) stage_d = ST_POLL;
        default:  stage_d = ST_POLL;
      endcase
    end
  end
endmodule

// File: rtl/chg_seq.sv
module chg_seq
  import chg_pkg::*;
#(
  parameter int POLL_MS        = 50,
  parameter int SS_SHORT_MS    = 120000,
  parameter int SS_LONG_MS     = 240000,
  parameter int TOP_SHORT_MS   = 7200000,
  parameter int TOP_LONG_MS    = 14400000,
  parameter int BLINK_SHORT_MS = 1000,
  parameter int BLINK_LONG_MS  = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ms_tick_i,
  input  logic [1:0] rate_sel_i,
  input  logic       bat_present_i,
  input  logic       ov_i,
  input  logic       uv_i,
  input  logic       hot_i,
  input  logic       cold_i,
  input  logic       slope_end_i,
  input  logic       fast_tmo_i,
  output logic [2:0] stage_o,
  output logic [2:0] mode_o,
  output logic       ind_sink_o
);
  localparam int MAXD = (TOP_LONG_MS > SS_LONG_MS) ? TOP_LONG_MS : SS_LONG_MS;
  localparam int CW   = $clog2(MAXD + 1);
  localparam logic [CW-1:0] POLL_END = CW'(POLL_MS);
  localparam logic [CW-1:0] SSS_LAST = CW'(SS_SHORT_MS - 1);
  localparam logic [CW-1:0] SSL_LAST = CW'(SS_LONG_MS - 1);
  localparam logic [CW-1:0] TPS_LAST = CW'(TOP_SHORT_MS - 1);
  localparam logic [CW-1:0] TPL_LAST = CW'(TOP_LONG_MS - 1);

  stage_e        stage_q, stage_d;
  mode_e         mode_q;
  logic          long_q;
  logic          entering;
  logic [CW-1:0] cnt;
  logic          poll_done, ss_done, top_done;
  logic          phase;

  assign entering  = (stage_d != stage_q);
  assign poll_done = (cnt >= POLL_END);
  assign ss_done   = ms_tick_i && (cnt == (long_q ? SSL_LAST : SSS_LAST));
  assign top_done  = ms_tick_i && (cnt == (long_q ? TPL_LAST : TPS_LAST));

  chg_timer #(.CW(CW)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .clr  (entering),
    .tick (ms_tick_i),
    .cnt  (cnt)
  );

  chg_next u_next (
    .stage_q   (stage_q),
    .poll_done (poll_done),
    .ss_done   (ss_done),
    .top_done  (top_done),
    .present   (bat_present_i),
    .ov        (ov_i),
    .uv        (uv_i),
    .hot       (hot_i),
    .cold      (cold_i),
    .slope_end (slope_end_i),
    .fast_tmo  (fast_tmo_i),
    .stage_d   (stage_d)
  );

  chg_blink #(
    .BLINK_SHORT_MS (BLINK_SHORT_MS),
    .BLINK_LONG_MS  (BLINK_LONG_MS)
  ) u_blink (
    .clk      (clk),
    .rst      (rst),
    .clr      (entering),
    .en       (is_blinking(stage_q)),
    .tick     (ms_tick_i),
    .long_sel (long_q),
    .phase    (phase)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= ST_POLL;
      mode_q  <= MD_OFF;
      long_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      mode_q  <= mode_of(stage_d);
      if ((stage_q == ST_POLL) && is_charging(stage_d)) begin
        long_q <= rate_sel_i[0];
      end
    end
  end

  assign stage_o    = stage_q;
  assign mode_o     = mode_q;
  assign ind_sink_o = (stage_q == ST_SOFT) || (stage_q == ST_FAST) ||
                      (is_blinking(stage_q) && phase);
endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       bat_present_i,
  input logic       ov_i,
  input logic       uv_i,
  input logic       hot_i,
  input logic [2:0] stage_o,
  input logic [2:0] mode_o,
  input logic       ind_sink_o
);
  logic charging;
  assign charging = (stage_o >= 3'd1) && (stage_o <= 3'd5);

  AST_POLL_NO_CHARGE: assert property (@(posedge clk) disable iff (rst)
    stage_o == 3'd0 |-> mode_o == 3'd0); // R2

  AST_SHUTDOWN_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    charging && (ov_i || uv_i || hot_i) |=> stage_o == 3'd6); // R9

  AST_FAULT_LATCHED: assert property (@(posedge clk) disable iff (rst)
    stage_o == 3'd6 && bat_present_i |=> stage_o == 3'd6); // R10

  AST_IND_DARK: assert property (@(posedge clk) disable iff (rst)
    (stage_o == 3'd0 || stage_o == 3'd6) |-> !ind_sink_o); // R12

  AST_FAST_FROM_SOFT: assert property (@(posedge clk) disable iff (rst)
    stage_o == 3'd2 && $past(stage_o) != 3'd2 |-> $past(stage_o) == 3'd1); // R4

  AST_MAINT_FROM_TOP: assert property (@(posedge clk) disable iff (rst)
    stage_o == 3'd4 && $past(stage_o) != 3'd4 |-> $past(stage_o) == 3'd3); // R6
endmodule

bind chg_seq chg_seq_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .bat_present_i (bat_present_i),
  .ov_i          (ov_i),
  .uv_i          (uv_i),
  .hot_i         (hot_i),
  .stage_o       (stage_o),
  .mode_o        (mode_o),
  .ind_sink_o    (ind_sink_o)
);

// File: tb/tb_chg_seq.sv
module tb_chg_seq;
  localparam int P_POLL = 3;
  localparam int P_SSS  = 4;
  localparam int P_SSL  = 8;
  localparam int P_TPS  = 10;
  localparam int P_TPL  = 20;
  localparam int P_BLS  = 2;
  localparam int P_BLL  = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [1:0] rate = 2'b00;
  logic       present = 1'b0, ov = 1'b0, uv = 1'b0, hot = 1'b0;
  logic       cold = 1'b0, slope = 1'b0, tmo = 1'b0;
  logic [2:0] stage, mode;
  logic       ind;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  chg_seq #(
    .POLL_MS(P_POLL), .SS_SHORT_MS(P_SSS), .SS_LONG_MS(P_SSL),
    .TOP_SHORT_MS(P_TPS), .TOP_LONG_MS(P_TPL),
    .BLINK_SHORT_MS(P_BLS), .BLINK_LONG_MS(P_BLL)
  ) dut (
    .clk(clk), .rst(rst), .ms_tick_i(tick), .rate_sel_i(rate),
    .bat_present_i(present), .ov_i(ov), .uv_i(uv), .hot_i(hot),
    .cold_i(cold), .slope_end_i(slope), .fast_tmo_i(tmo),
    .stage_o(stage), .mode_o(mode), .ind_sink_o(ind)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic run_rate(input int r);
    int ss, tp, bl;
    ss = r[0] ? P_SSL : P_SSS;
    tp = r[0] ? P_TPL : P_TPS;
    bl = r[0] ? P_BLL : P_BLS;
    rst = 1'b1; present = 0; ov = 0; uv = 0; hot = 0; cold = 0; slope = 0; tmo = 0;
    rate = 2'(r);
    step(); step();
    chk("R1 stage in reset", stage, 0);
    rst = 1'b0;
    step();
    chk("R1 stage", stage, 0);
    chk("R1 mode", mode, 0);
    chk("R1 ind", ind, 0);

    present = 1'b1;
    ticks(P_POLL - 1);
    chk("R2 still polling", stage, 0);
    chk("R2 no charge", mode, 0);
    ticks(1); step();
    chk("R2 to soft-start", stage, 1);
    chk("R11 ramp mode", mode, 1);
    chk("R12 steady on soft", ind, 1);
    rate = 2'(r ^ 1); // R13: flip rate after latch

    ticks(ss - 1);
    chk("R4 soft held", stage, 1);
    ticks(1);
    chk("R4 fast entry", stage, 2);
    chk("R11 full mode", mode, 2);

    ticks(3);
    chk("R5 fast held", stage, 2);
    if (r % 2 == 0) slope = 1'b1; else tmo = 1'b1;
    step();
    slope = 1'b0; tmo = 1'b0;
    chk("R5 to topping", stage, 3);
    chk("R11 topping mode", mode, 3);
    chk("R12 blink starts on", ind, 1);

    cold = 1'b1;
    ticks(bl - 1);
    chk("R8 cold ignored in topping", stage, 3);
    chk("R12 blink before half", ind, 1);
    ticks(1);
    chk("R12 blink R13 half period", ind, 0);
    cold = 1'b0;
    ticks(bl);
    chk("R12 blink back on", ind, 1);
    ticks(tp - 2 * bl - 1);
    chk("R6 topping held R13", stage, 3);
    ticks(1);
    chk("R6 to maintenance", stage, 4);
    chk("R11 maint mode", mode, 4);

    ticks(5);
    chk("R7 maint held", stage, 4);
    present = 1'b0;
    step();
    chk("R7 removal to poll", stage, 0);
    chk("R7 mode off", mode, 0);

    present = 1'b1; cold = 1'b1;
    ticks(P_POLL); step();
    chk("R8 cold charge", stage, 5);
    chk("R8 cold mode", mode, 3);
    ticks(3);
    chk("R8 cold held", stage, 5);
    cold = 1'b0;
    step();
    chk("R8 warm to soft", stage, 1);

    case (r)
      0: ov = 1'b1;
      1: uv = 1'b1;
      2: hot = 1'b1;
      default: begin ov = 1'b1; tick = 1'b1; end
    endcase
    step();
    tick = 1'b0;
    chk("R9 shutdown", stage, 6);
    chk("R10 mode off", mode, 0);
    chk("R12 ind open", ind, 0);
    ov = 0; uv = 0; hot = 0;
    ticks(3);
    chk("R10 fault held", stage, 6);
    present = 1'b0;
    step();
    chk("R10 release to poll", stage, 0);

    ov = 1'b1;
    ticks(P_POLL); step();
    chk("R3 poll overvoltage", stage, 6);
    ov = 1'b0;
    step();
    chk("R3 empty returns to poll", stage, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1 (run did not end)");
    finish_run();
  end

  initial begin
    for (int r = 0; r < 4; r++) run_rate(r);
    finish_run();
  end
endmodule